// File: doc/BRIEF.md
# Bit-Serial Multiply-by-45 Unit

This block scales a two's-complement word by the constant 45. The word arrives one bit per clock, least significant bit first, and the product leaves the same way. The multiplier is a small graph of bit-serial adders and subtractors. Each power-of-two weight in the graph is a chain of flip-flops on the serial path. A build-time parameter picks one of two graphs. The first is a cascade of two adders that forms 9x and then 5·(9x). The second sums the signed digits 64x − 16x − 4x + x and needs three units.

A caller raises `in_start` with the least significant input bit and then supplies the remaining W−1 data bits on the following clocks. Each word then occupies W+6 bit slots. During the last six slots the block repeats the captured sign bit in place of the input, so the whole product fits in the word. A new word may begin in the slot directly after the last slot of the previous one. The product appears one clock after its input bit, framed by `out_first` and `out_valid`.

Top module: `mul45_serial`

## Requirements
- R1: With the two-adder factored structure selected, the W+6 output bits of a word, taken least significant first, form the two's-complement value 45·x, where x is the signed W-bit input of that word.
- R2: With the signed-digit structure selected, every word yields exactly the same output bits as in R1.
- R3: The most negative and the most positive W-bit inputs produce products that are correct as signed W+6-bit values, with no wrap-around.
- R4: `out_first` is high for exactly the one clock that follows the clock in which `in_start` was sampled high. `out_valid` is high from that clock for W+6 consecutive clocks.
- R5: `in_bit` is ignored in slots W through W+5 of a word. Those slots take the sign bit that was sampled in slot W−1.
- R6: A word that starts in the slot right after the previous word ends is computed as if the block were fresh. No carry or delayed bit crosses from one word into the next.
- R7: While reset is high, and on the first clock after it, `out_bit`, `out_first` and `out_valid` are all 0.
- R8: Whenever `out_valid` is low, `out_bit` is 0, whatever `in_bit` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_start | input | 1 | High with the least significant bit of a new input word |
| in_bit | input | 1 | Serial input data, least significant bit first |
| out_bit | output | 1 | Serial product, least significant bit first |
| out_first | output | 1 | Marks the first product bit of a word |
| out_valid | output | 1 | High for every product bit of a word |

## Verification
The bench builds two copies of the block, both with W = 8. One copy uses the factored graph and the other uses the signed-digit graph. Every copy is driven with the same stimulus. With W = 8 an exhaustive sweep of all 256 input values, sent back to back, is cheap. That sweep compares each copy with 45·x and with the other copy. It also places deliberate junk in the extension slots and carries words across frame boundaries. The extreme inputs −128 and 127 reach the top of the 14-bit product range.

// File: rtl/mul45_pkg.sv
package mul45_pkg;

    typedef enum logic {
        ARCH_FACTORED = 1'b0,
        ARCH_CSD      = 1'b1
    } arch_e;

    // 45 < 2**6, so six extra bit slots hold the full product
    localparam int EXT_BITS = 6;

    typedef struct packed {
        logic bit_v;
        logic first;
        logic valid;
    } ser_out_t;

    function automatic int frame_len(input int width);
        return width + EXT_BITS;
    endfunction

endpackage

// File: rtl/ser_delay.sv
// Multiply-by-2**DEPTH on an LSB-first stream: a chain of DEPTH flops,
// zero-filled when a new word starts.
module ser_delay #(
    parameter int DEPTH = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic din,
    output logic tap
);
    logic [DEPTH-1:0] sr_q;

    assign tap = clear ? 1'b0 : sr_q[DEPTH-1];

    always_ff @(posedge clk) begin
        if (rst)
            sr_q <= '0;
        else if (clear)
            sr_q <= DEPTH'(din);
        else
            sr_q <= (sr_q << 1) | DEPTH'(din);
    end
endmodule

// File: rtl/ser_addsub.sv
// One node of the adder graph: s = a + b, or s = a - b when SUBTRACT is set.
module ser_addsub #(
    parameter bit SUBTRACT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic a,
    input  logic b,
    output logic s
);
    logic carry_q;
    logic b_eff;
    logic c_in;

    assign b_eff = b ^ SUBTRACT;
    assign c_in  = clear ? SUBTRACT : carry_q;
    assign s     = a ^ b_eff ^ c_in;

    always_ff @(posedge clk) begin
        if (rst)
            carry_q <= 1'b0;
        else
            carry_q <= (a & b_eff) | (a & c_in) | (b_eff & c_in);
    end
endmodule

// File: rtl/frame_seq.sv
// Tracks the slot within a word and substitutes the sign in extension slots.
module frame_seq #(
    parameter int W     = 8,
    parameter int FRAME = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic in_start,
    input  logic in_bit,
    output logic active,
    output logic x_ext
);
    localparam int CW = $clog2(FRAME);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] idx;
    logic          sign_q;

    assign idx    = in_start ? '0 : cnt_q;
    assign active = in_start | (cnt_q != '0);
    assign x_ext  = (int'(idx) < W) ? in_bit : sign_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            sign_q <= 1'b0;
        end else begin
            if (in_start)
                cnt_q <= CW'(1);
            else if (cnt_q != '0)
                cnt_q <= (cnt_q == CW'(FRAME - 1)) ? '0 : cnt_q + 1'b1;
            if (active && int'(idx) == W - 1)
                sign_q <= in_bit;
        end
    end
endmodule

// File: rtl/mul45_serial.sv
module mul45_serial
    import mul45_pkg::*;
#(
    parameter int    W    = 8,
    parameter arch_e ARCH = ARCH_FACTORED
) (
    input  logic clk,
    input  logic rst,
    input  logic in_start,
    input  logic in_bit,
    output logic out_bit,
    output logic out_first,
    output logic out_valid
);
    localparam int FRAME = frame_len(W);

    logic     active;
    logic     x_ext;
    logic     prod;
    ser_out_t out_q;

    frame_seq #(.W(W), .FRAME(FRAME)) u_seq (
        .clk(clk), .rst(rst), .in_start(in_start), .in_bit(in_bit),
        .active(active), .x_ext(x_ext)
    );

    generate
        if (ARCH == ARCH_FACTORED) begin : g_factored
            logic x8, y9, y36;
            // y = x + 8x
            ser_delay #(.DEPTH(3)) u_d3 (
                .clk(clk), .rst(rst), .clear(in_start), .din(x_ext), .tap(x8));
            ser_addsub #(.SUBTRACT(1'b0)) u_add1 (
                .clk(clk), .rst(rst), .clear(in_start), .a(x_ext), .b(x8), .s(y9));
            // p = y + 4y
            ser_delay #(.DEPTH(2)) u_d2 (
                .clk(clk), .rst(rst), .clear(in_start), .din(y9), .tap(y36));
            ser_addsub #(.SUBTRACT(1'b0)) u_add2 (
                .clk(clk), .rst(rst), .clear(in_start), .a(y9), .b(y36), .s(prod));
        end else begin : g_csd
            logic x64, x16, x4, t48, t44;
            ser_delay #(.DEPTH(6)) u_d6 (
                .clk(clk), .rst(rst), .clear(in_start), .din(x_ext), .tap(x64));
            ser_delay #(.DEPTH(4)) u_d4 (
                .clk(clk), .rst(rst), .clear(in_start), .din(x_ext), .tap(x16));
            ser_delay #(.DEPTH(2)) u_d2 (
                .clk(clk), .rst(rst), .clear(in_start), .din(x_ext), .tap(x4));
            ser_addsub #(.SUBTRACT(1'b1)) u_sub1 (
                .clk(clk), .rst(rst), .clear(in_start), .a(x64), .b(x16), .s(t48));
            ser_addsub #(.SUBTRACT(1'b1)) u_sub2 (
                .clk(clk), .rst(rst), .clear(in_start), .a(t48), .b(x4), .s(t44));
            ser_addsub #(.SUBTRACT(1'b0)) u_add3 (
                .clk(clk), .rst(rst), .clear(in_start), .a(t44), .b(x_ext), .s(prod));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= '0;
        else
            out_q <= '{bit_v: active & prod, first: in_start, valid: active};
    end

    assign out_bit   = out_q.bit_v;
    assign out_first = out_q.first;
    assign out_valid = out_q.valid;
endmodule

// File: rtl/mul45_serial_chk.sv
module mul45_serial_chk #(
    parameter int FRAME = 14
) (
    input logic clk,
    input logic rst,
    input logic in_start,
    input logic out_bit,
    input logic out_first,
    input logic out_valid
);
    localparam int RW = $clog2(FRAME + 1) + 1;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else if (out_first)
            run_q <= RW'(1);
        else if (out_valid)
            run_q <= run_q + 1'b1;
        else
            run_q <= '0;
    end

    a_r4_first_after_start: assert property (@(posedge clk) disable iff (rst)
        in_start |=> out_first);
    a_r4_first_needs_start: assert property (@(posedge clk) disable iff (rst)
        out_first |-> $past(in_start));
    a_r4_first_is_valid: assert property (@(posedge clk) disable iff (rst)
        out_first |-> out_valid);
    a_r4_run_in_range: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_first) |-> (run_q != '0 && int'(run_q) < FRAME));
    a_r4_full_length: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> int'(run_q) == FRAME);
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !out_bit);
endmodule

bind mul45_serial mul45_serial_chk #(.FRAME(FRAME)) u_chk (
    .clk(clk), .rst(rst), .in_start(in_start), .out_bit(out_bit),
    .out_first(out_first), .out_valid(out_valid)
);

// File: tb/mul45_serial_tb.sv
module mul45_serial_tb;
    import mul45_pkg::*;

    localparam int W     = 8;
    localparam int FRAME = W + 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_start = 1'b0;
    logic in_bit = 1'b0;
    logic ob_f, of_f, ov_f, ob_c, of_c, ov_c;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    mul45_serial #(.W(W), .ARCH(ARCH_FACTORED)) u_dut (
        .clk(clk), .rst(rst), .in_start(in_start), .in_bit(in_bit),
        .out_bit(ob_f), .out_first(of_f), .out_valid(ov_f));

    mul45_serial #(.W(W), .ARCH(ARCH_CSD)) u_dut_csd (
        .clk(clk), .rst(rst), .in_start(in_start), .in_bit(in_bit),
        .out_bit(ob_c), .out_first(of_c), .out_valid(ov_c));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Sends one word; ext slots carry junk. Checks framing per bit and the products.
    task automatic run_word(input int v, input string tag);
        logic [FRAME-1:0] got_f, got_c, exp_p;
        logic [W-1:0] vb;
        bit frame_ok;
        vb = W'(v);
        exp_p = FRAME'(v * 45);
        frame_ok = 1'b1;
        for (int k = 0; k < FRAME; k++) begin
            in_start = (k == 0);
            in_bit   = (k < W) ? vb[k] : logic'(((k * 7 + v) >> 1) & 1);
            @(posedge clk);
            @(negedge clk);
            got_f[k] = ob_f;
            got_c[k] = ob_c;
            if (of_f != (k == 0) || of_c != (k == 0) || !ov_f || !ov_c)
                frame_ok = 1'b0;
        end
        in_start = 1'b0;
        check(frame_ok, "R4 framing", int'(frame_ok), 1);
        check(got_f == exp_p, {tag, " factored"}, int'(signed'(got_f)), int'(signed'(exp_p)));
        check(got_c == exp_p, {"R2 csd ", tag}, int'(signed'(got_c)), int'(signed'(exp_p)));
    endtask

    task automatic idle_cycles(input int n);
        bit ok;
        ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            in_start = 1'b0;
            in_bit   = logic'(i & 1);
            @(posedge clk);
            @(negedge clk);
            if (ov_f || ov_c || ob_f || ob_c || of_f || of_c) ok = 1'b0;
        end
        check(ok, "R8 idle outputs zero", int'(ok), 1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({ob_f, of_f, ov_f, ob_c, of_c, ov_c} == 6'b0, "R7 in reset", 1, 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check({ob_f, of_f, ov_f, ob_c, of_c, ov_c} == 6'b0, "R7 after reset", 1, 0);
    endtask

    task automatic t_sweep();
        // back to back, every value; junk in ext slots exercises R5, R6
        for (int v = -(1 << (W - 1)); v < (1 << (W - 1)); v++)
            run_word(v, "R1 R5 sweep");
    endtask

    task automatic t_extremes();
        idle_cycles(5);
        run_word(-(1 << (W - 1)), "R3 min");
        run_word((1 << (W - 1)) - 1, "R3 max");
    endtask

    task automatic t_leak();
        run_word(-1, "R6 before");
        run_word(0, "R6 zero after minus one");
        run_word(-128, "R6 before");
        run_word(1, "R6 one after min");
        idle_cycles(4);
    endtask

    initial begin
        t_reset();
        idle_cycles(3);
        t_sweep();
        t_extremes();
        t_leak();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule